// File: doc/BRIEF.md
# Rational-Ratio Pulse-Skipping Strobe Generator

This block derives a one-cycle enable strobe from a fast system clock. The long-run strobe rate is exactly the rational fraction N/D of the clock rate. With a 50 MHz clock and the pair 537/1250, the average is 21.48 MHz. Downstream logic stays on the system clock and advances only in cycles where the strobe is high. No second clock net is built.

A register accumulates N every running cycle. Its modulus is D itself rather than a power of two, so the ratio carries no rounding error. When the sum reaches D, the register wraps and the strobe fires. Each strobe edge can therefore sit up to one input period away from its ideal position, but the average rate is exact. A build-time parameter selects a binary phase-accumulator engine instead. That engine first derives a fixed increment floor(N·2^W/D) with a serial divider, and its average rate then matches the ratio only approximately.

A four-state controller sequences the block. IDLE captures the ratio and holds the strobe low. IDLE goes to FAULT when `run` rises with a bad ratio, and goes to PREP when `run` rises with a good one. PREP goes to RUN once the engine's preparation is done: after one cycle for the modulo engine, and after W divider cycles for the binary one. RUN strobes until `run` drops. PREP, RUN and FAULT all go back to IDLE when `run` is low.

Top module: `frac_strobe_gen`

## Requirements
- R1: While `rst` is high, and after it, `strobe` and `cfg_bad` are 0, and the block sits in IDLE until `run` rises.
- R2: `num_in` and `den_in` are captured on each clock edge where the block is in IDLE and `run` is 0. Changes to them while `run` is 1 have no effect on the strobe pattern.
- R3: Counting the k-th RUN cycle as k = 1, 2, and so on, the strobe seen after that cycle's edge equals floor(kN/D) − floor((k−1)N/D) in the modulo engine (PHASE_MODE = 0).
- R4: Over the first D RUN cycles, the modulo engine issues exactly N strobes.
- R5: The spacing between consecutive strobes is always floor(D/N) or ceil(D/N) cycles. For 537/1250 this is 2 or 3.
- R6: A ratio with N = 0 or N ≥ D sends the block to FAULT when `run` rises. There `cfg_bad` is 1 and `strobe` is 0 until `run` drops, after which `cfg_bad` returns to 0.
- R7: Dropping `run` returns the block to IDLE. From the second edge on, `strobe` stays 0. The accumulator is cleared, so a restart repeats the same sequence.
- R8: The first RUN cycle follows the edge at which `run` was seen high by exactly 1 + P cycles. P is 1 for the modulo engine and W + 1 for the binary engine.
- R9: With PHASE_MODE = 1, the increment is floor(N·2^W/D) for W = PHASE_W. The strobe is the carry out of a W-bit phase register, so k RUN cycles give floor(k·inc/2^W) strobes. For 537/1250 this comes to 536 strobes in 1250 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Start and hold strobing; low returns to IDLE |
| num_in | input | DEN_W | Ratio numerator N |
| den_in | input | DEN_W | Ratio denominator D |
| strobe | output | 1 | One-cycle enable pulse at average rate N/D |
| cfg_bad | output | 1 | High in FAULT, when the captured ratio is invalid |

## Verification
The bench walks ratios chosen to stress the wrap logic:
- Below one half, at the default.
- Above one half, where strobes fall in back-to-back cycles.
- One short of D, which skips a single strobe.
- Dividing evenly, which gives a fixed spacing.

A wrong comparison, such as wrapping on a strict greater-than or failing to subtract D, shifts the per-cycle sequence and breaks the N-in-D count. A latch that stays open while running would let a mid-run change to the ratio corrupt the pattern. A missing clear on stop would make a restart resume from a stale phase. The invalid ratios N = 0 and N = D must park in FAULT silently. The binary engine must show exactly the one-strobe shortfall that its truncated increment predicts.

// File: rtl/frac_pkg.sv
package frac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PREP  = 2'd1,
        ST_RUN   = 2'd2,
        ST_FAULT = 2'd3
    } fs_state_e;

    localparam int ENGINE_MODULO = 0;
    localparam int ENGINE_BINARY = 1;

endpackage

// File: rtl/frac_cfg_regs.sv
module frac_cfg_regs #(
    parameter int DEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DEN_W-1:0] num_in,
    input  logic [DEN_W-1:0] den_in,
    output logic [DEN_W-1:0] num_q,
    output logic [DEN_W-1:0] den_q,
    output logic             ratio_ok
);

    always_ff @(posedge clk) begin
        if (rst) begin
            num_q <= '0;
            den_q <= '0;
        end else if (load) begin
            num_q <= num_in;
            den_q <= den_in;
        end
    end

    // valid only for 0 < N < D
    always_comb begin
        ratio_ok = (num_q != '0) && (num_q < den_q);
    end

endmodule

// File: rtl/frac_mod_engine.sv
module frac_mod_engine #(
    parameter int DEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic [DEN_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             prep_done,
    output logic             strobe
);

    localparam int ACC_W = DEN_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] wrapped;
    logic             hit;

    always_comb begin
        sum     = acc_q + {1'b0, num};
        hit     = (sum >= {1'b0, den});
        wrapped = hit ? (sum - {1'b0, den}) : sum;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q  <= '0;
            strobe <= 1'b0;
        end else if (step) begin
            acc_q  <= wrapped;
            strobe <= hit;
        end else begin
            strobe <= 1'b0;
        end
    end

    assign prep_done = 1'b1;

    // R3: residue stays below the modulus while stepping
    p_acc_bound_r3: assert property (@(posedge clk) disable iff (rst)
        step |-> (acc_q < {1'b0, den}));

    // R3: a strobe only follows a stepping cycle
    p_strobe_after_step_r3: assert property (@(posedge clk) disable iff (rst)
        strobe |-> $past(step));

endmodule

// File: rtl/frac_bin_engine.sv
module frac_bin_engine #(
    parameter int DEN_W   = 11,
    parameter int PHASE_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             prep,
    input  logic             step,
    input  logic [DEN_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             prep_done,
    output logic             strobe
);

    localparam int CNT_W = $clog2(PHASE_W + 1);

    logic [DEN_W-1:0]   rem_q;
    logic [PHASE_W-1:0] quo_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [PHASE_W-1:0] phase_q;

    logic [DEN_W:0]     shifted;
    logic [DEN_W:0]     diff;
    logic               ge;
    logic [PHASE_W:0]   phase_sum;
    logic               unused_bits;

    always_comb begin
        shifted   = {rem_q, 1'b0};
        ge        = (shifted >= {1'b0, den});
        diff      = shifted - {1'b0, den};
        phase_sum = {1'b0, phase_q} + {1'b0, quo_q};
        prep_done = (cnt_q == CNT_W'(PHASE_W));
    end

    assign unused_bits = diff[DEN_W];

    // serial restoring divider: quo = floor(num * 2^PHASE_W / den)
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rem_q <= num;
            quo_q <= '0;
            cnt_q <= '0;
        end else if (prep && !prep_done) begin
            rem_q <= ge ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
            quo_q <= {quo_q[PHASE_W-2:0], ge};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase_q <= '0;
            strobe  <= 1'b0;
        end else if (step) begin
            phase_q <= phase_sum[PHASE_W-1:0];
            strobe  <= phase_sum[PHASE_W];
        end else begin
            strobe  <= 1'b0;
        end
    end

    // R9: partial remainder stays below the divisor during preparation
    p_rem_bound_r9: assert property (@(posedge clk) disable iff (rst)
        prep |-> (rem_q < den));

    // R9: no strobe emerges from a preparation cycle
    p_quiet_prep_r9: assert property (@(posedge clk) disable iff (rst)
        (prep && !step) |=> !strobe);

endmodule

// File: rtl/frac_strobe_gen.sv
module frac_strobe_gen
    import frac_pkg::*;
#(
    parameter int DEN_W      = 11,
    parameter int PHASE_MODE = 0,
    parameter int PHASE_W    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DEN_W-1:0] num_in,
    input  logic [DEN_W-1:0] den_in,
    output logic             strobe,
    output logic             cfg_bad
);

    fs_state_e        state_q;
    fs_state_e        state_nx;
    logic [DEN_W-1:0] num_q;
    logic [DEN_W-1:0] den_q;
    logic             ratio_ok;
    logic             cfg_load;
    logic             eng_clear;
    logic             eng_prep;
    logic             eng_step;
    logic             prep_done;

    frac_cfg_regs #(.DEN_W(DEN_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (cfg_load),
        .num_in   (num_in),
        .den_in   (den_in),
        .num_q    (num_q),
        .den_q    (den_q),
        .ratio_ok (ratio_ok)
    );

    generate
        if (PHASE_MODE == ENGINE_BINARY) begin : g_binary
            frac_bin_engine #(.DEN_W(DEN_W), .PHASE_W(PHASE_W)) u_engine (
                .clk       (clk),
                .rst       (rst),
                .clear     (eng_clear),
                .prep      (eng_prep),
                .step      (eng_step),
                .num       (num_q),
                .den       (den_q),
                .prep_done (prep_done),
                .strobe    (strobe)
            );
        end else begin : g_modulo
            logic unused_prep;
            assign unused_prep = eng_prep;
            frac_mod_engine #(.DEN_W(DEN_W)) u_engine (
                .clk       (clk),
                .rst       (rst),
                .clear     (eng_clear),
                .step      (eng_step),
                .num       (num_q),
                .den       (den_q),
                .prep_done (prep_done),
                .strobe    (strobe)
            );
        end
    endgenerate

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (run) state_nx = ratio_ok ? ST_PREP : ST_FAULT;
            ST_PREP:  if (!run) state_nx = ST_IDLE;
                      else if (prep_done) state_nx = ST_RUN;
            ST_RUN:   if (!run) state_nx = ST_IDLE;
            ST_FAULT: if (!run) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // per-state controls
    always_comb begin
        cfg_load  = 1'b0;
        eng_clear = 1'b0;
        eng_prep  = 1'b0;
        eng_step  = 1'b0;
        cfg_bad   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cfg_load  = !run;
                eng_clear = 1'b1;
            end
            ST_PREP:  eng_prep  = 1'b1;
            ST_RUN:   eng_step  = 1'b1;
            ST_FAULT: begin
                cfg_bad   = 1'b1;
                eng_clear = 1'b1;
            end
            default:  eng_clear = 1'b1;
        endcase
    end

    // R2: captured ratio frozen whenever run is high
    p_cfg_freeze_r2: assert property (@(posedge clk) disable iff (rst)
        run |=> ($stable(num_q) && $stable(den_q)));

    // R7: outside RUN the next strobe is low
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_RUN) |=> !strobe);

    // R6: flag and strobe never high together
    p_fault_silent_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_bad |-> !strobe);

    // R6: a bad ratio seen at start raises the flag
    p_fault_entry_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && run && !ratio_ok) |=> cfg_bad);

endmodule

// File: tb/frac_strobe_gen_bench.sv
module frac_strobe_gen_bench;

    localparam int DW = 11;
    localparam int PW = 32;
    localparam int NV = 6;
    // N, D, min gap, max gap
    localparam int VEC [NV][4] = '{
        '{537, 1250, 2, 3},
        '{1,   4,    4, 4},
        '{3,   7,    2, 3},
        '{5,   7,    1, 2},
        '{2046, 2047, 1, 2},
        '{2,   6,    3, 3}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run_m = 1'b0;
    logic          run_b = 1'b0;
    logic [DW-1:0] num_in = '0;
    logic [DW-1:0] den_in = '0;
    logic          stb_m, bad_m, stb_b, bad_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int r_seq, r_cnt, r_gmin, r_gmax, r_total;

    always #2 clk = ~clk;

    frac_strobe_gen #(.DEN_W(DW)) u_frac_strobe_gen (
        .clk(clk), .rst(rst), .run(run_m), .num_in(num_in), .den_in(den_in),
        .strobe(stb_m), .cfg_bad(bad_m)
    );

    frac_strobe_gen #(.DEN_W(DW), .PHASE_MODE(1), .PHASE_W(PW)) u_bin (
        .clk(clk), .rst(rst), .run(run_b), .num_in(num_in), .den_in(den_in),
        .strobe(stb_b), .cfg_bad(bad_b)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_bit(input bit bin, input int n, input int d, input int k);
        longint unsigned inc, a, b;
        if (bin) begin
            inc = (longint'(n) << PW) / longint'(d);
            a = (longint'(k) * inc) >> PW;
            b = (longint'(k - 1) * inc) >> PW;
        end else begin
            a = longint'(k) * n / d;
            b = longint'(k - 1) * n / d;
        end
        return int'(a - b);
    endfunction

    task automatic run_window(input bit bin, input int n, input int d, input int span,
                              input bit scramble);
        int last;
        bit s;
        last = -1;
        r_seq = 0; r_cnt = 0; r_gmin = 1 << 30; r_gmax = 0; r_total = 0;
        @(negedge clk);
        num_in = DW'(n);
        den_in = DW'(d);
        @(negedge clk);
        @(negedge clk);
        if (bin) run_b = 1'b1; else run_m = 1'b1;
        repeat (bin ? PW + 2 : 2) @(posedge clk);
        for (int k = 1; k <= span; k++) begin
            @(posedge clk);
            @(negedge clk);
            s = bin ? stb_b : stb_m;
            if (int'(s) != exp_bit(bin, n, d, k)) r_seq++;
            if (s) begin
                r_total++;
                if (k <= d) r_cnt++;
                if (last >= 0) begin
                    if (k - last < r_gmin) r_gmin = k - last;
                    if (k - last > r_gmax) r_gmax = k - last;
                end
                last = k;
            end
            if (scramble && k == 3) begin
                num_in = DW'(1);
                den_in = DW'(4);
            end
        end
        run_m = 1'b0;
        run_b = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", "run did not end", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(stb_m == 1'b0, "R1", "strobe in reset", stb_m, 0);
        check(bad_m == 1'b0, "R1", "flag in reset", bad_m, 0);
        rst = 1'b0;
        num_in = DW'(3);
        den_in = DW'(7);
        repeat (5) @(negedge clk);
        check(stb_m == 1'b0 && bad_m == 1'b0, "R1", "idle outputs", {stb_m, bad_m}, 0);

        // table walk: R3 R8 sequence, R4 count, R5 gaps
        for (int v = 0; v < NV; v++) begin
            run_window(1'b0, VEC[v][0], VEC[v][1], 2 * VEC[v][1], 1'b0);
            check(r_seq == 0, "R3 R8", $sformatf("sequence %0d/%0d mismatches", VEC[v][0], VEC[v][1]), r_seq, 0);
            check(r_cnt == VEC[v][0], "R4", $sformatf("strobes in D for %0d/%0d", VEC[v][0], VEC[v][1]), r_cnt, VEC[v][0]);
            check(r_gmin == VEC[v][2] && r_gmax == VEC[v][3], "R5",
                  $sformatf("gap range for %0d/%0d (min*100+max)", VEC[v][0], VEC[v][1]),
                  r_gmin * 100 + r_gmax, VEC[v][2] * 100 + VEC[v][3]);
        end

        // R2: ratio inputs changed mid-run are ignored
        run_window(1'b0, 3, 7, 14, 1'b1);
        check(r_seq == 0, "R2", "pattern after mid-run input change", r_seq, 0);
        check(r_total == 6, "R2", "strobes in 14 cycles", r_total, 6);

        // R7: stop and restart repeats the sequence, strobe low after stop
        run_window(1'b0, 5, 7, 9, 1'b0);
        check(stb_m == 1'b0, "R7", "strobe after stop", stb_m, 0);
        run_window(1'b0, 5, 7, 9, 1'b0);
        check(r_seq == 0, "R7", "restart sequence mismatches", r_seq, 0);

        // R6: invalid ratios
        @(negedge clk);
        num_in = DW'(0);
        den_in = DW'(5);
        repeat (2) @(negedge clk);
        run_m = 1'b1;
        @(negedge clk);
        check(bad_m == 1'b1, "R6", "flag for N=0", bad_m, 1);
        r_total = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (stb_m) r_total++;
        end
        check(r_total == 0 && bad_m == 1'b1, "R6", "strobes while N=0", r_total, 0);
        run_m = 1'b0;
        @(negedge clk);
        check(bad_m == 1'b0, "R6", "flag cleared after stop", bad_m, 0);
        num_in = DW'(9);
        den_in = DW'(9);
        repeat (2) @(negedge clk);
        run_m = 1'b1;
        repeat (6) @(negedge clk);
        check(bad_m == 1'b1 && stb_m == 1'b0, "R6", "N=D flag,strobe", {bad_m, stb_m}, 2);
        run_m = 1'b0;
        repeat (3) @(negedge clk);

        // R9: binary engine
        run_window(1'b1, 537, 1250, 1250, 1'b0);
        check(r_seq == 0, "R9 R8", "binary sequence mismatches", r_seq, 0);
        check(r_cnt == 536, "R9", "binary strobes in 1250", r_cnt, 536);

        done = 1'b1;
        report();
        $finish;
    end

endmodule